// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte is written into a one-entry holding register by a one-cycle strobe. As soon as the frame shifter is free, the byte moves into the shifter and the holding register can take the next byte. Each frame has these parts, in order:

- a low start bit,
- 5 to 8 data bits, least significant bit first,
- an optional parity bit,
- one or two high stop bits.

A 16-bit divisor sets the bit rate. The system clock is divided by the divisor to give a tick at sixteen times the bit rate, and each bit lasts sixteen ticks.

The frame format comes from a set of line-control inputs. The shifter reads them when it loads each byte. A break input holds the line low for as long as it is set. Two status flags are provided:

- holding-empty: a new byte may be written,
- idle: nothing is held and nothing is being shifted.

Top module: `ser_tx`

## Requirements
- R1: Each bit on `txd_o` lasts exactly 16·D clock cycles, where D is `divisor_i`. A frame started from idle begins on the clock edge after the one that loads the byte. The last stop bit ends exactly 16·D·N cycles later, where N is the frame length in bits.
- R2: From idle the line is high. A frame starts with one low start bit. The data bits follow, least significant bit first.
- R3: `wlen_i` selects the data bit count: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above that count are not sent.
- R4: `two_stop_i`=0 sends one high stop bit and `two_stop_i`=1 sends two.
- R5: With `par_en_i`=1 and `par_stick_i`=0, one parity bit follows the data. It is computed over the sent data bits only. `par_even_i`=1 makes the total count of ones in data plus parity even, and `par_even_i`=0 makes it odd. With `par_en_i`=0 no parity bit is sent.
- R6: With `par_en_i`=1 and `par_stick_i`=1, the parity bit is the constant inverse of `par_even_i`.
- R7: While `brk_i`=1, `txd_o` is low. Frame timing goes on underneath, so a frame interrupted by a break still ends at its normal time.
- R8: After reset `txd_o`=1, `hold_empty_o`=1 and `idle_o`=1. A write clears `hold_empty_o` on the next edge. When the shifter is free it takes the byte one cycle later and sets `hold_empty_o` again. `idle_o` is 1 only when the holding register is empty and no frame is in progress.
- R9: If the holding register is full when a frame's last stop bit ends, the next frame's start bit begins on that same edge, with no idle gap.
- R10: A divisor of 0 behaves exactly like a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle strobe that writes `wr_data_i` into the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| wlen_i | input | 2 | Data bit count select (5 + value) |
| two_stop_i | input | 1 | 1: two stop bits, 0: one |
| par_en_i | input | 1 | Parity bit enable |
| par_even_i | input | 1 | 1: even parity, 0: odd |
| par_stick_i | input | 1 | Forces a constant parity bit |
| brk_i | input | 1 | Holds the line low while set |
| divisor_i | input | 16 | Clock cycles per oversampling tick (0 acts as 1) |
| txd_o | output | 1 | Serial output line |
| hold_empty_o | output | 1 | Holding register can take a byte |
| idle_o | output | 1 | No byte held and no frame in progress |

## Verification
The bench sends frames for every word length, both stop counts and each parity mode, including stick parity. It samples each bit at its midpoint, so a design that sent the most significant bit first, or computed parity over the masked-off bits, would show wrong bit values. It checks `idle_o` one cycle before and one cycle after the computed frame end. An off-by-one tick count, a missing second stop bit, or a zero divisor that stalls the tick generator would move that edge.

A second byte written during a frame must start on the very edge the first frame's stop bit ends; a one-bit idle gap would show as a high line where a low start bit is expected. A break applied in the middle of a frame must pull the line low without delaying the frame's end.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int MAX_DATA = 8;
  localparam int MIN_DATA = 5;
  localparam int FRAME_W  = MAX_DATA + 4;  // start + data + parity + 2 stop
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int OVS      = 16;
  localparam int OVS_W    = $clog2(OVS);

  typedef struct packed {
    logic       stick;
    logic       even;
    logic       pen;
    logic       two_stop;
    logic [1:0] wlen;
  } line_cfg_t;
endpackage

// File: rtl/ser_tx_tick.sv
module ser_tx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // zero divisor acts as one
  assign lim    = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end

  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i && div_i > DIV_W'(1)) |=> (!tick_o || !$stable(div_i)));
endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= (full_q & ~load_i) | wr_i;
      if (wr_i) data_q <= data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  assert_load_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> full_q);
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  line_cfg_t           cfg_i,
  input  logic [MAX_DATA-1:0] data_i,
  input  logic                full_i,
  output logic                load_o,
  output logic                clr_o,
  output logic                busy_o,
  output logic                line_o
);
  logic [FRAME_W-1:0]  sreg_q;
  logic [CNT_W-1:0]    bit_cnt_q;
  logic [OVS_W-1:0]    sub_q;
  logic                busy_q;

  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    nd;
  logic [CNT_W-1:0]    len;
  logic [MAX_DATA-1:0] mask;
  logic                par;
  logic                bit_end;
  logic                last;

  assign nd   = CNT_W'(MIN_DATA) + CNT_W'(cfg_i.wlen);
  assign mask = {MAX_DATA{1'b1}} >> (2'd3 - cfg_i.wlen);
  assign par  = cfg_i.stick ? ~cfg_i.even
              : (cfg_i.even ? ^(data_i & mask) : ~^(data_i & mask));
  assign len  = CNT_W'(2) + nd + CNT_W'(cfg_i.pen) + CNT_W'(cfg_i.two_stop);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < int'(nd)) frame[i+1] = data_i[i];
    for (int i = MIN_DATA; i <= MAX_DATA; i++)
      if (cfg_i.pen && i == int'(nd)) frame[i+1] = par;
  end

  assign bit_end = busy_q & tick_i & (sub_q == OVS_W'(OVS - 1));
  assign last    = bit_end & (bit_cnt_q == CNT_W'(1));
  assign load_o  = full_i & (~busy_q | last);
  // align the tick phase to a frame started from idle
  assign clr_o   = load_o & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q    <= '1;
      bit_cnt_q <= '0;
      sub_q     <= '0;
      busy_q    <= 1'b0;
    end else if (load_o) begin
      sreg_q    <= frame;
      bit_cnt_q <= len;
      sub_q     <= '0;
      busy_q    <= 1'b1;
    end else if (last) begin
      sreg_q    <= '1;
      bit_cnt_q <= '0;
      sub_q     <= '0;
      busy_q    <= 1'b0;
    end else if (busy_q && tick_i) begin
      sub_q <= sub_q + OVS_W'(1);
      if (bit_end) begin
        sreg_q    <= {1'b1, sreg_q[FRAME_W-1:1]};
        bit_cnt_q <= bit_cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = sreg_q[0];

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !sreg_q[0]);
  assert_bits_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bit_cnt_q != '0 && bit_cnt_q <= CNT_W'(FRAME_W)));
  assert_stop_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bit_cnt_q == CNT_W'(1)) |-> sreg_q[0]);
endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [1:0]       wlen_i,
  input  logic             two_stop_i,
  input  logic             par_en_i,
  input  logic             par_even_i,
  input  logic             par_stick_i,
  input  logic             brk_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             txd_o,
  output logic             hold_empty_o,
  output logic             idle_o
);
  line_cfg_t           cfg;
  logic                tick, clr, load, full, busy, line;
  logic [MAX_DATA-1:0] hold_data;

  assign cfg = '{stick: par_stick_i, even: par_even_i, pen: par_en_i,
                 two_stop: two_stop_i, wlen: wlen_i};

  ser_tx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr), .div_i(divisor_i), .tick_o(tick)
  );

  ser_tx_hold #(.DATA_W(MAX_DATA)) u_hold (
    .clk_i (clk_i), .rst_ni(rst_ni), .wr_i(wr_en_i), .data_i(wr_data_i),
    .load_i(load), .full_o(full), .data_o(hold_data)
  );

  ser_tx_shift u_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .cfg_i(cfg), .data_i(hold_data),
    .full_i(full), .load_o(load), .clr_o(clr), .busy_o(busy), .line_o(line)
  );

  assign txd_o        = line & ~brk_i;
  assign hold_empty_o = ~full;
  assign idle_o       = ~busy & ~full;

  assert_idle_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !brk_i) |-> txd_o);
endmodule

// File: tb/tb_ser_tx.sv
module tb_ser_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  wlen = 2'b11;
  logic        two_stop = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic        brk = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic        txd, hold_empty, idle;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  ser_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wlen_i(wlen), .two_stop_i(two_stop), .par_en_i(par_en), .par_even_i(par_even),
    .par_stick_i(par_stick), .brk_i(brk), .divisor_i(divisor),
    .txd_o(txd), .hold_empty_o(hold_empty), .idle_o(idle)
  );

  // {divisor, stick, even, pen, two_stop, wlen, data}
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {16'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 8'hA5},
    {16'd2, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 8'h3C},
    {16'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 8'h5A},
    {16'd3, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 8'hFF},
    {16'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'h81},
    {16'd1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 8'h7E},
    {16'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 8'h13},
    {16'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'hC3}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // expected line bits of a frame, bit k sent k-th
  function automatic int frame_len(input logic [5:0] c);
    return 1 + 5 + int'(c[1:0]) + int'(c[3]) + 1 + int'(c[2]);
  endfunction

  function automatic logic [11:0] frame_exp(input logic [7:0] d, input logic [5:0] c);
    logic [11:0] f;
    int nd;
    int ones;
    logic p;
    nd = 5 + int'(c[1:0]);
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      if (d[i]) ones++;
    end
    if (c[5])      p = ~c[4];              // R6 stick
    else if (c[4]) p = (ones % 2) == 1;    // R5 even
    else           p = (ones % 2) == 0;    // R5 odd
    if (c[3]) f[nd+1] = p;
    return f;
  endfunction

  task automatic set_cfg(input logic [5:0] c, input logic [15:0] d);
    par_stick = c[5]; par_even = c[4]; par_en = c[3]; two_stop = c[2]; wlen = c[1:0];
    divisor = d;
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [5:0] c, input logic [15:0] dv);
    int de, n;
    logic [11:0] f;
    string tag;
    de = (dv == 0) ? 1 : int'(dv);
    n  = frame_len(c);
    f  = frame_exp(d, c);
    tag = (dv == 0) ? "R10" : (c[5] ? "R6" : (c[3] ? "R5" : "R3"));
    @(negedge clk);
    set_cfg(c, dv);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);                       // W+0.5
    wr_en = 1'b0;
    chk("R8 empty after write", hold_empty, 1'b0);
    chk("R8 busy after write", idle, 1'b0);
    @(negedge clk);                       // W+1.5
    chk("R8 empty after load", hold_empty, 1'b1);
    chk("R2 start bit", txd, 1'b0);
    repeat (8*de - 1) @(negedge clk);     // mid of bit 0
    for (int k = 0; k < n; k++) begin
      if (k == 0)           chk("R2 start mid", txd, f[k]);
      else if (k >= n - 1 - int'(c[2])) chk("R4 stop", txd, f[k]);
      else                  chk(tag, txd, f[k]);
      if (k < n - 1) repeat (16*de) @(negedge clk);
    end
    repeat (8*de) @(negedge clk);
    chk("R1 frame not yet ended", idle, 1'b0);
    @(negedge clk);
    chk("R1 frame ended", idle, 1'b1);
    chk("R8 idle line high", txd, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset txd", txd, 1'b1);
    chk("R8 reset empty", hold_empty, 1'b1);
    chk("R8 reset idle", idle, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][7:0], VEC[v][13:8], VEC[v][29:14]);

    // R9: back-to-back frames, 8N1, divisor 1
    @(negedge clk);
    set_cfg(6'b000011, 16'd1);
    wr_data = 8'h55; wr_en = 1'b1;
    @(negedge clk);                       // W+0.5
    wr_en = 1'b0;
    @(negedge clk);                       // W+1.5
    wr_data = 8'hB6; wr_en = 1'b1;
    @(negedge clk);                       // W+2.5
    wr_en = 1'b0;
    repeat (158) @(negedge clk);          // W+160.5, last stop of first frame
    chk("R9 first stop", txd, 1'b1);
    chk("R9 second held", hold_empty, 1'b0);
    @(negedge clk);                       // W+161.5
    chk("R9 no gap start", txd, 1'b0);
    chk("R9 no idle between", idle, 1'b0);
    chk("R9 second loaded", hold_empty, 1'b1);
    repeat (24) @(negedge clk);           // mid of first data bit
    chk("R9 second data bit0", txd, 1'b0);
    repeat (16) @(negedge clk);
    chk("R9 second data bit1", txd, 1'b1);
    wait (idle === 1'b1);
    repeat (2) @(negedge clk);

    // R7: break while idle
    brk = 1'b1;
    @(negedge clk);
    chk("R7 break idle low", txd, 1'b0);
    brk = 1'b0;
    @(negedge clk);
    chk("R7 break released", txd, 1'b1);

    // R7: break mid-frame does not change frame length (8N1, D=1: 160 cycles)
    wr_data = 8'hFF; wr_en = 1'b1;
    @(negedge clk);                       // W+0.5
    wr_en = 1'b0;
    repeat (140) @(negedge clk);          // W+140.5, in a data bit of value 1
    brk = 1'b1;
    @(negedge clk);
    chk("R7 break mid-frame low", txd, 1'b0);
    brk = 1'b0;
    @(negedge clk);                       // W+142.5
    chk("R7 line restored", txd, 1'b1);
    repeat (18) @(negedge clk);           // W+160.5
    chk("R7 frame still running", idle, 1'b0);
    @(negedge clk);                       // W+161.5
    chk("R7 frame ends on time", idle, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule